// File: doc/BRIEF.md
# SPI Flash Dummy-Byte Inserter

This block sits in the byte path between a host that writes SPI flash commands one byte at a time and the serial shifter that drives the flash. Each time chip select goes active, it treats the next byte as a flash opcode. It decodes how many dummy units that opcode needs and counts the address bytes that follow: three, or four when the wide-address mode input is set. When the host offers the first byte after the address, the block drops that byte. In its place it sends eight filler bytes per dummy unit, and the filler value comes from a small programmable register.

When no dummies are needed, all bytes pass straight through. This covers the time before an opcode, unknown opcodes, opcodes that need zero dummies, everything after the dummy burst, and any time chip select is inactive. While the burst is being sent, the host handshake is held off.

Control FSM states: ST_OFF (pass-through, snooping disabled), ST_OPCODE (armed, waiting for the opcode), ST_ADDR (counting address bytes), ST_DATA_WAIT (next host byte will be dropped), ST_DUMMY (emitting filler). Transitions:
- An inactive chip select forces ST_OFF from any state.
- A rising chip select moves ST_OFF to ST_OPCODE.
- An accepted opcode moves ST_OPCODE to ST_ADDR, or to ST_OFF when it needs zero units.
- The last accepted address byte moves ST_ADDR to ST_DATA_WAIT.
- A host byte offered in ST_DATA_WAIT moves to ST_DUMMY.
- The last filler byte accepted by the shifter moves ST_DUMMY to ST_OFF.

Top module: `spi_dummy_inserter`

## Requirements
- R1: After reset the block is in pass-through: a host byte with chip select inactive appears unchanged at the output, and the filler register reads 0x00.
- R2: Opcodes 0x02, 0x03, 0x12, 0x13, 0x32, 0x34 and 0xA2 need zero dummy units; their entire command stream, data bytes included, passes through unchanged.
- R3: Any opcode outside the lists in R2, R4 and R5 is treated as needing no dummies, and its whole stream passes through unchanged.
- R4: Opcodes 0x0B, 0x3B, 0x3C, 0x6B and 0x6C need one unit. After the address bytes, the next host byte is dropped and exactly 8 filler bytes are sent in its place. Later host bytes then pass unchanged.
- R5: Opcodes 0x0C, 0xBB and 0xBC need two units (16 filler bytes). Opcodes 0xEB and 0xEC need four units (32 filler bytes).
- R6: With addr4=0 the dropped byte is the 5th byte after the opcode edge (opcode plus 3 address bytes pass first). With addr4=1 it is the 6th byte (4 address bytes pass first).
- R7: A register write to offset 0x54 stores bits [7:0] of the write data as the filler byte. A read at 0x54 returns that byte zero-extended.
- R8: A read at any other register offset returns all ones.
- R9: From the dropped byte until the shifter accepts the last filler byte, in_ready stays low. Under shifter back-pressure, the filler count and order are preserved.
- R10: Deasserting chip select ends snooping at once. The next chip-select assertion re-arms it for a new opcode.
- R11: Only the first byte after a chip-select assertion is decoded. Bytes following a completed dummy burst, with chip select still active, pass unchanged even if they match dummy opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_active | input | 1 | Flash chip select is active (level) |
| addr4 | input | 1 | 1: four address bytes, 0: three |
| in_valid | input | 1 | Host offers a byte |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Host byte accepted this cycle |
| out_valid | output | 1 | Byte offered to the shifter |
| out_data | output | 8 | Byte to the shifter |
| out_ready | input | 1 | Shifter accepts the byte |
| reg_addr | input | 8 | Control register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
If the snoop state is wrong, the byte stream at the shifter shows it on the very next transfer of the affected command. Examples are a filler byte where a data byte belongs, a missing or extra filler byte, or the host's dropped byte leaking through. A wrong address counter moves the dropped byte by one position, and a wrong dummy counter changes the burst length; both show up as a mismatch within 32 transfers. A stuck state shows up either as in_ready staying low, or as snooping that misses re-arming on the next chip-select edge.

// File: rtl/spi_dmi_pkg.sv
package spi_dmi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA_WAIT,
        ST_DUMMY
    } snoop_state_e;

    // Dummy units (eight filler bytes each) needed by a flash opcode.
    function automatic logic [2:0] dummy_units(input logic [BYTE_W-1:0] op);
        logic [2:0] u;
        unique case (op)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: u = 3'd1;
            8'hBB, 8'h0C, 8'hBC:               u = 3'd2;
            8'hEB, 8'hEC:                      u = 3'd4;
            default:                           u = 3'd0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/dmi_opcode_decode.sv
module dmi_opcode_decode
    import spi_dmi_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [BYTE_W-1:0] opcode,
    output logic [CNT_W-1:0]  dummy_bytes
);
    logic [2:0] units;

    always_comb begin
        units       = dummy_units(opcode);
        dummy_bytes = CNT_W'(units) << 3;
    end
endmodule

// File: rtl/dmi_filler_reg.sv
module dmi_filler_reg
    import spi_dmi_pkg::*;
#(
    parameter int          RA_W     = 8,
    parameter int          REG_W    = 32,
    parameter logic [7:0]  FILL_OFS = 8'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [BYTE_W-1:0] fill
);
    localparam logic [RA_W-1:0] OFS = RA_W'(FILL_OFS);

    logic hit;

    always_comb hit = (reg_addr == OFS);

    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (reg_wen && hit)
            fill <= reg_wdata[BYTE_W-1:0];
    end

    always_comb reg_rdata = hit ? REG_W'(fill) : '1;
endmodule

// File: rtl/spi_dummy_inserter.sv
module spi_dummy_inserter
    import spi_dmi_pkg::*;
#(
    parameter int         MAX_UNITS = 4,
    parameter int         RA_W      = 8,
    parameter int         REG_W     = 32,
    parameter logic [7:0] FILL_OFS  = 8'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              addr4,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int DCW = $clog2(MAX_UNITS * 8 + 1);
    localparam int ACW = 3;

    snoop_state_e       st, nxt;
    logic               cs_q;
    logic [DCW-1:0]     dcnt;
    logic [DCW-1:0]     dec_bytes;
    logic [ACW-1:0]     acnt;
    logic [ACW-1:0]     addr_last;
    logic [BYTE_W-1:0]  fill;
    logic               cs_rise, hs_in, hs_out;

    dmi_opcode_decode #(.CNT_W(DCW)) u_dec (
        .opcode      (in_data),
        .dummy_bytes (dec_bytes)
    );

    dmi_filler_reg #(.RA_W(RA_W), .REG_W(REG_W), .FILL_OFS(FILL_OFS)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fill      (fill)
    );

    always_comb begin
        cs_rise   = cs_active && !cs_q;
        hs_in     = in_valid && in_ready;
        hs_out    = out_valid && out_ready;
        addr_last = addr4 ? ACW'(3) : ACW'(2);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_OFF;
            cs_q <= 1'b0;
        end else begin
            st   <= nxt;
            cs_q <= cs_active;
        end
    end

    // Address and dummy counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt <= '0;
            dcnt <= '0;
        end else begin
            unique case (st)
                ST_OPCODE: if (hs_in) begin
                    acnt <= '0;
                    dcnt <= dec_bytes;
                end
                ST_ADDR:   if (hs_in)  acnt <= acnt + 1'b1;
                ST_DUMMY:  if (hs_out) dcnt <= dcnt - 1'b1;
                default: ;
            endcase
        end
    end

    // Next state
    always_comb begin
        nxt = st;
        if (!cs_active) begin
            nxt = ST_OFF;
        end else if (cs_rise) begin
            nxt = ST_OPCODE;
        end else begin
            unique case (st)
                ST_OFF:       nxt = ST_OFF;
                ST_OPCODE:    if (hs_in) nxt = (dec_bytes == '0) ? ST_OFF : ST_ADDR;
                ST_ADDR:      if (hs_in && acnt == addr_last) nxt = ST_DATA_WAIT;
                ST_DATA_WAIT: if (in_valid) nxt = ST_DUMMY;
                ST_DUMMY:     if (hs_out && dcnt == DCW'(1)) nxt = ST_OFF;
                default:      nxt = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
        unique case (st)
            ST_DATA_WAIT: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            ST_DUMMY: begin
                out_valid = 1'b1;
                out_data  = fill;
                in_ready  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmi_checker.sv
module dmi_checker
    import spi_dmi_pkg::*;
#(
    parameter int         MAX_UNITS = 4,
    parameter int         RA_W      = 8,
    parameter int         REG_W     = 32,
    parameter logic [7:0] FILL_OFS  = 8'h54,
    parameter int         DCW       = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_active,
    input logic               in_ready,
    input logic               out_valid,
    input logic [7:0]         out_data,
    input logic [RA_W-1:0]    reg_addr,
    input logic               reg_wen,
    input logic [REG_W-1:0]   reg_wdata,
    input snoop_state_e       st,
    input logic [DCW-1:0]     dcnt,
    input logic [BYTE_W-1:0]  fill
);
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (st == ST_OFF));

    p_cs_low_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (st == ST_OFF));

    p_dummy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DUMMY) |-> (!in_ready && out_valid));

    p_dummy_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DUMMY) |-> (out_data == fill));

    p_swallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA_WAIT) |-> !out_valid);

    p_fill_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == RA_W'(FILL_OFS)) |=> (fill == $past(reg_wdata[7:0])));

    p_dcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= DCW'(MAX_UNITS * 8));
endmodule

bind spi_dummy_inserter dmi_checker #(
    .MAX_UNITS (MAX_UNITS),
    .RA_W      (RA_W),
    .REG_W     (REG_W),
    .FILL_OFS  (FILL_OFS),
    .DCW       (DCW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .st        (st),
    .dcnt      (dcnt),
    .fill      (fill)
);

// File: tb/test_spi_dummy_inserter.sv
module test_spi_dummy_inserter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_active = 1'b0, addr4 = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       bp_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic [7:0] fill_val = 8'h00;

    always #2 clk = ~clk;  // 250 MHz

    spi_dummy_inserter i_spi_dummy_inserter (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int units(input logic [7:0] op);
        case (op)
            8'h0B, 8'h3B, 8'h3C, 8'h6B, 8'h6C: return 1;
            8'h0C, 8'hBB, 8'hBC:               return 2;
            8'hEB, 8'hEC:                      return 4;
            default:                           return 0;
        endcase
    endfunction

    // shifter back-pressure
    always @(negedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= bp_en ? lfsr[0] : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected byte", {24'd0, out_data}, 32'd0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data == e, t, {24'd0, out_data}, {24'd0, e});
            end
        end
    end

    task automatic expect_byte(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #0.5 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string t);
        @(negedge clk);
        reg_addr = a;
        #1 check(reg_rdata == exp, t, reg_rdata, exp);
    endtask

    // full command: opcode, address, optional dummy phase, data bytes
    task automatic txn(input logic [7:0] op, input int ndata, input string t);
        int u, na;
        u  = units(op);
        na = addr4 ? 4 : 3;
        @(negedge clk) cs_active = 1'b1;
        @(negedge clk);
        expect_byte(op, t);
        send(op);
        for (int i = 0; i < na; i++) begin
            expect_byte(8'hA0 + 8'(i), t);
            send(8'hA0 + 8'(i));
        end
        if (u != 0) begin
            for (int i = 0; i < u * 8; i++) expect_byte(fill_val, t);
            send(8'hEE);  // dropped
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'h77;
            #1 check(in_ready == 1'b0, "R9 in_ready during dummies", {31'd0, in_ready}, 32'd0);
            in_valid = 1'b0;
        end
        for (int i = 0; i < ndata; i++) begin
            expect_byte(8'h10 + 8'(i), t);
            send(8'h10 + 8'(i));
        end
        drain();
        @(negedge clk) cs_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check(8'h54, 32'h0, "R1 filler after reset");
        expect_byte(8'h5C, "R1 pass-through");
        send(8'h5C);
        drain();

        // R7 / R8 registers
        write_reg(8'h54, 32'hDEAD_BE3C);
        read_check(8'h54, 32'h0000_003C, "R7 filler low byte");
        read_check(8'h50, 32'hFFFF_FFFF, "R8 unimplemented read");
        read_check(8'h58, 32'hFFFF_FFFF, "R8 unimplemented read");
        fill_val = 8'h3C;

        // R2 zero-dummy opcodes
        txn(8'h03, 3, "R2 op03");
        txn(8'hA2, 2, "R2 opA2");
        txn(8'h34, 2, "R2 op34");
        // R3 unknown opcode
        txn(8'h9F, 4, "R3 unknown");
        // R4 one unit, R11 later dummy-looking bytes pass
        txn(8'h0B, 2, "R4 op0B");
        @(negedge clk) cs_active = 1'b1;
        @(negedge clk);
        expect_byte(8'h6B, "R11 op6B"); send(8'h6B);
        for (int i = 0; i < 3; i++) begin expect_byte(8'hB0 + 8'(i), "R11 addr"); send(8'hB0 + 8'(i)); end
        for (int i = 0; i < 8; i++) expect_byte(fill_val, "R11 dummies");
        send(8'hEE);
        expect_byte(8'hEB, "R11 no redecode"); send(8'hEB);
        expect_byte(8'h0B, "R11 no redecode"); send(8'h0B);
        for (int i = 0; i < 5; i++) begin expect_byte(8'hC0 + 8'(i), "R11 trailing"); send(8'hC0 + 8'(i)); end
        drain();
        @(negedge clk) cs_active = 1'b0;

        // R5 two and four units, with back-pressure (R9)
        write_reg(8'h54, 32'h0000_00A5);
        fill_val = 8'hA5;
        bp_en = 1'b1;
        txn(8'hBB, 2, "R5 opBB");
        txn(8'hEC, 3, "R5 opEC R9 backpressure");
        // R6 four-byte address mode
        addr4 = 1'b1;
        txn(8'h3C, 2, "R6 op3C addr4");
        txn(8'h0C, 1, "R6 op0C addr4");
        bp_en = 1'b0;
        addr4 = 1'b0;

        // R10 abort mid-address, then re-arm
        @(negedge clk) cs_active = 1'b1;
        @(negedge clk);
        expect_byte(8'h0B, "R10 abort op"); send(8'h0B);
        expect_byte(8'hA0, "R10 abort addr"); send(8'hA0);
        drain();
        @(negedge clk) cs_active = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin expect_byte(8'h20 + 8'(i), "R10 cs low pass"); send(8'h20 + 8'(i)); end
        drain();
        txn(8'h6C, 1, "R10 rearm");

        check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule